// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR SRAM Model

This block is a cycle-accurate, synthesizable model of a static RAM with a separate read data port and a separate write data port, where every accepted command moves a burst of four words. One active-low read enable, one active-low write enable and one shared address are sampled on each rising clock edge. Each clock cycle carries two beats per data port, shown as a rise-beat word and a fall-beat word, so a burst of four takes two clock cycles on its port.

Acceptance depends on history as well as on the present inputs. A port that has just accepted a command is still busy with the second half of its burst on the next edge, so a request of the same kind on that edge is dropped. The read and write ports keep separate state, so a read burst and a write burst can overlap freely, even at the same address. Write beats carry per-lane enables that choose which byte lanes are stored.

Top module: `burst4_sram`

## Requirements
- R1: Enables and address count only at the rising clock edge. An edge where both enables are high starts no burst, and a pulse on the enables between edges has no effect on outputs or memory.
- R2: A read accepted at edge E places beats 0 and 1 on rdDataRise and rdDataFall, with rdValidRise and rdValidFall high, in the cycle after edge E+1, and beats 2 and 3 in the cycle after edge E+2.
- R3: A burst at base address A visits words whose two low address bits are A+0, A+1, A+2 and A+3 modulo 4, with the upper address bits held, so A=6 visits 6, 7, 4, 5.
- R4: A read request at the edge right after an accepted read is dropped, and a request two edges after an accepted read is accepted, which gives gapless back-to-back bursts.
- R5: The write port follows the same rule: a write request at the edge right after an accepted write is dropped.
- R6: For a write accepted at edge E, the rise and fall data sampled at edge E+1 go to beats 0 and 1 and those at edge E+2 to beats 2 and 3. Enable bit i (1 = store) of wrLaneRise or wrLaneFall guards bits [i*LANE_W +: LANE_W] of that beat, and a lane that is not enabled keeps its old content.
- R7: A read burst and a write burst run at the same time without changing each other's timing, addresses or data.
- R8: A read beat of a word that is written at the same edge returns the content from before that write.
- R9: In any cycle that carries no read beat, both valid flags are low and both read data words are zero.
- R10: While reset is held low, the valid flags and read data are zero. The first command after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEnN | input | 1 | Read request, active low |
| wrEnN | input | 1 | Write request, active low |
| addr | input | ADDR_W | Burst base address, shared by both ports |
| wrDataRise | input | WORD_W | Write word for the even beat of the cycle |
| wrDataFall | input | WORD_W | Write word for the odd beat of the cycle |
| wrLaneRise | input | WORD_W/LANE_W | Lane enables for wrDataRise |
| wrLaneFall | input | WORD_W/LANE_W | Lane enables for wrDataFall |
| rdDataRise | output | WORD_W | Read word for the even beat of the cycle |
| rdDataFall | output | WORD_W | Read word for the odd beat of the cycle |
| rdValidRise | output | 1 | rdDataRise carries a burst beat |
| rdValidFall | output | 1 | rdDataFall carries a burst beat |

## Verification
The bench builds the block with its defaults: an 18-bit word split into two 9-bit lanes and a 6-bit address, which gives 64 words. With 64 words the whole array can be written in sixteen bursts, and random addresses often hit unaligned bases that wrap, or a read and a write at the same word. Two lanes give every enable pattern (none, low, high, both) on each beat, so partial writes and fully masked writes are both exercised.

// File: rtl/burst4_sram_pkg.sv
package burst4_sram_pkg;

  // Progress of one port through its two-cycle burst
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic rdLoad;   // capture read base address
    logic rdHalf0;  // emit beats 0 and 1
    logic rdHalf1;  // emit beats 2 and 3
    logic wrLoad;   // capture write base address
    logic wrHalf0;  // store beats 0 and 1
    logic wrHalf1;  // store beats 2 and 3
  } ctl_s;

endpackage

// File: rtl/burst4_sram_ctrl.sv
module burst4_sram_ctrl
  import burst4_sram_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rdEnN,
  input  logic wrEnN,
  output ctl_s ctl
);

  localparam int NPORTS = 2;  // index 0 = read, 1 = write

  logic [NPORTS-1:0] enN;
  logic [NPORTS-1:0] load;
  logic [NPORTS-1:0] half0;
  logic [NPORTS-1:0] half1;

  assign enN = {wrEnN, rdEnN};

  // The same acceptance machine, once per port
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    phase_e phase;
    phase_e phaseNext;
    logic   accept;

    always_comb begin
      // a port in its first burst cycle ignores a new request (R4, R5)
      accept = !enN[p] && (phase != PH_FIRST);
      if (accept)                 phaseNext = PH_FIRST;
      else if (phase == PH_FIRST) phaseNext = PH_SECOND;
      else                        phaseNext = PH_IDLE;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) phase <= PH_IDLE;
      else       phase <= phaseNext;
    end

    assign load[p]  = accept;
    assign half0[p] = (phase == PH_FIRST);
    assign half1[p] = (phase == PH_SECOND);
  end

  assign ctl.rdLoad  = load[0];
  assign ctl.rdHalf0 = half0[0];
  assign ctl.rdHalf1 = half1[0];
  assign ctl.wrLoad  = load[1];
  assign ctl.wrHalf0 = half0[1];
  assign ctl.wrHalf1 = half1[1];

endmodule

// File: rtl/burst4_sram_dpath.sv
module burst4_sram_dpath
  import burst4_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctl_s                      ctl,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         wrDataRise,
  input  logic [WORD_W-1:0]         wrDataFall,
  input  logic [WORD_W/LANE_W-1:0]  wrLaneRise,
  input  logic [WORD_W/LANE_W-1:0]  wrLaneFall,
  output logic [WORD_W-1:0]         rdDataRise,
  output logic [WORD_W-1:0]         rdDataFall,
  output logic                      rdValidRise,
  output logic                      rdValidFall
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = WORD_W / LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdBase;
  logic [ADDR_W-1:0] wrBase;

  // word of a burst: upper bits fixed, two low bits wrap (R3)
  function automatic logic [ADDR_W-1:0] beatAddr(input logic [ADDR_W-1:0] base,
                                                 input logic [1:0] idx);
    logic [1:0] low;
    low = base[1:0] + idx;
    return {base[ADDR_W-1:2], low};
  endfunction

  logic              rdActive;
  logic              wrActive;
  logic [1:0]        rdSel;
  logic [1:0]        wrSel;
  logic [ADDR_W-1:0] rdAddrRise;
  logic [ADDR_W-1:0] rdAddrFall;
  logic [ADDR_W-1:0] wrAddrRise;
  logic [ADDR_W-1:0] wrAddrFall;

  assign rdActive   = ctl.rdHalf0 | ctl.rdHalf1;
  assign wrActive   = ctl.wrHalf0 | ctl.wrHalf1;
  assign rdSel      = ctl.rdHalf1 ? 2'd2 : 2'd0;
  assign wrSel      = ctl.wrHalf1 ? 2'd2 : 2'd0;
  assign rdAddrRise = beatAddr(rdBase, rdSel);
  assign rdAddrFall = beatAddr(rdBase, rdSel + 2'd1);
  assign wrAddrRise = beatAddr(wrBase, wrSel);
  assign wrAddrFall = beatAddr(wrBase, wrSel + 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBase <= '0;
      wrBase <= '0;
    end else begin
      if (ctl.rdLoad) rdBase <= addr;
      if (ctl.wrLoad) wrBase <= addr;
    end
  end

  // lane-masked array write; reads at the same edge see old words (R8)
  always_ff @(posedge clk) begin
    if (wrActive) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrLaneRise[l]) mem[wrAddrRise][l*LANE_W +: LANE_W] <= wrDataRise[l*LANE_W +: LANE_W];
        if (wrLaneFall[l]) mem[wrAddrFall][l*LANE_W +: LANE_W] <= wrDataFall[l*LANE_W +: LANE_W];
      end
    end
  end

  // registered read beats, zero when idle (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataRise  <= '0;
      rdDataFall  <= '0;
      rdValidRise <= 1'b0;
      rdValidFall <= 1'b0;
    end else if (rdActive) begin
      rdDataRise  <= mem[rdAddrRise];
      rdDataFall  <= mem[rdAddrFall];
      rdValidRise <= 1'b1;
      rdValidFall <= 1'b1;
    end else begin
      rdDataRise  <= '0;
      rdDataFall  <= '0;
      rdValidRise <= 1'b0;
      rdValidFall <= 1'b0;
    end
  end

endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
  import burst4_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rdEnN,
  input  logic                      wrEnN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         wrDataRise,
  input  logic [WORD_W-1:0]         wrDataFall,
  input  logic [WORD_W/LANE_W-1:0]  wrLaneRise,
  input  logic [WORD_W/LANE_W-1:0]  wrLaneFall,
  output logic [WORD_W-1:0]         rdDataRise,
  output logic [WORD_W-1:0]         rdDataFall,
  output logic                      rdValidRise,
  output logic                      rdValidFall
);

  ctl_s ctl;

  burst4_sram_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .rdEnN (rdEnN),
    .wrEnN (wrEnN),
    .ctl   (ctl)
  );

  burst4_sram_dpath #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .LANE_W (LANE_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .addr        (addr),
    .wrDataRise  (wrDataRise),
    .wrDataFall  (wrDataFall),
    .wrLaneRise  (wrLaneRise),
    .wrLaneFall  (wrLaneFall),
    .rdDataRise  (rdDataRise),
    .rdDataFall  (rdDataFall),
    .rdValidRise (rdValidRise),
    .rdValidFall (rdValidFall)
  );

endmodule

// File: rtl/burst4_sram_chk.sv
module burst4_sram_chk
  import burst4_sram_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEnN,
  input logic              wrEnN,
  input ctl_s              ctl,
  input logic [WORD_W-1:0] rdDataRise,
  input logic [WORD_W-1:0] rdDataFall,
  input logic              rdValidRise,
  input logic              rdValidFall
);

  // R1: both enables high start nothing
  p_deselect_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnN && wrEnN) |-> !(ctl.rdLoad || ctl.wrLoad));

  // R2: first beat pair appears two samples after acceptance
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdLoad |-> ##2 (rdValidRise && rdValidFall));

  // R2: a burst spans at least two cycles of beats
  p_burst_span_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValidRise) |=> rdValidRise);

  // R4: no read acceptance on the edge after a read acceptance
  p_read_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdLoad |=> !ctl.rdLoad);

  // R5: no write acceptance on the edge after a write acceptance
  p_write_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrLoad |=> !ctl.wrLoad);

  // R9: idle read port shows zero data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdValidRise |-> (rdDataRise == '0 && rdDataFall == '0 && !rdValidFall));

  // R9: valid beats only follow an accepted read
  p_valid_origin_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValidRise |-> ($past(ctl.rdLoad, 2) || $past(ctl.rdLoad, 3)));

endmodule

bind burst4_sram burst4_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdEnN       (rdEnN),
  .wrEnN       (wrEnN),
  .ctl         (ctl),
  .rdDataRise  (rdDataRise),
  .rdDataFall  (rdDataFall),
  .rdValidRise (rdValidRise),
  .rdValidFall (rdValidFall)
);

// File: tb/burst4_sram_bench.sv
`timescale 1ns/1ps
module burst4_sram_bench;

  localparam int ADDR_W = 6;
  localparam int WORD_W = 18;
  localparam int LANE_W = 9;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdEnN = 1'b1;
  logic              wrEnN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wrDataRise = '0;
  logic [WORD_W-1:0] wrDataFall = '0;
  logic [LANES-1:0]  wrLaneRise = '0;
  logic [LANES-1:0]  wrLaneFall = '0;
  logic [WORD_W-1:0] rdDataRise;
  logic [WORD_W-1:0] rdDataFall;
  logic              rdValidRise;
  logic              rdValidFall;

  always #5 clk = ~clk;

  burst4_sram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_burst4_sram (
    .clk(clk), .rstN(rstN), .rdEnN(rdEnN), .wrEnN(wrEnN), .addr(addr),
    .wrDataRise(wrDataRise), .wrDataFall(wrDataFall),
    .wrLaneRise(wrLaneRise), .wrLaneFall(wrLaneFall),
    .rdDataRise(rdDataRise), .rdDataFall(rdDataFall),
    .rdValidRise(rdValidRise), .rdValidFall(rdValidFall)
  );

  int    checks = 0;
  int    failures = 0;
  string tag = "R10";

  // ---------------- reference model ----------------
  bit [WORD_W-1:0] refMem [DEPTH];
  int              rdQ[$];
  int              wrQ[$];
  bit              rdBusy = 0;
  bit              wrBusy = 0;
  bit [WORD_W-1:0] expRise = '0;
  bit [WORD_W-1:0] expFall = '0;
  bit              expValid = 0;

  function automatic int burstWord(int base, int i);
    return (base & ~3) | ((base + i) & 3);
  endfunction

  function automatic bit [WORD_W-1:0] merge(bit [WORD_W-1:0] old, bit [WORD_W-1:0] nw,
                                            bit [LANES-1:0] en);
    bit [WORD_W-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (en[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      rdQ.delete(); wrQ.delete();
      rdBusy = 0; wrBusy = 0;
      expRise = '0; expFall = '0; expValid = 0;
    end else begin
      int a0, a1;
      if (rdQ.size() > 0) begin
        a0 = rdQ.pop_front(); a1 = rdQ.pop_front();
        expRise = refMem[a0]; expFall = refMem[a1]; expValid = 1;
      end else begin
        expRise = '0; expFall = '0; expValid = 0;
      end
      if (wrQ.size() > 0) begin
        a0 = wrQ.pop_front(); a1 = wrQ.pop_front();
        refMem[a0] = merge(refMem[a0], wrDataRise, wrLaneRise);
        refMem[a1] = merge(refMem[a1], wrDataFall, wrLaneFall);
      end
      if (!rdEnN && !rdBusy) begin
        for (int i = 0; i < 4; i++) rdQ.push_back(burstWord(int'(addr), i));
        rdBusy = 1;
      end else rdBusy = 0;
      if (!wrEnN && !wrBusy) begin
        for (int i = 0; i < 4; i++) wrQ.push_back(burstWord(int'(addr), i));
        wrBusy = 1;
      end else wrBusy = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (rdValidRise !== expValid || rdValidFall !== expValid ||
          rdDataRise !== expRise || rdDataFall !== expFall) begin
        failures++;
        $display("FAIL %s t=%0t actual v=%0b%0b rise=%h fall=%h expected v=%0b rise=%h fall=%h",
                 tag, $time, rdValidRise, rdValidFall, rdDataRise, rdDataFall,
                 expValid, expRise, expFall);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(bit rn, bit wn, int a, bit [LANES-1:0] mR = '1, bit [LANES-1:0] mF = '1);
    @(negedge clk);
    rdEnN = rn; wrEnN = wn; addr = ADDR_W'(a);
    wrDataRise = WORD_W'($urandom); wrDataFall = WORD_W'($urandom);
    wrLaneRise = mR; wrLaneFall = mF;
  endtask

  // enables pulse low strictly between rising edges (R1)
  task automatic glitch(int a);
    @(posedge clk);
    #1; rdEnN = 0; wrEnN = 0; addr = ADDR_W'(a);
    #2; rdEnN = 1; wrEnN = 1;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (rdValidRise !== 0 || rdValidFall !== 0 || rdDataRise !== '0 || rdDataFall !== '0) begin
      failures++;
      $display("FAIL R10 reset actual v=%0b%0b rise=%h fall=%h expected all zero",
               rdValidRise, rdValidFall, rdDataRise, rdDataFall);
    end
    rstN = 1;

    tag = "R6 fill";
    for (int i = 0; i < DEPTH / 4; i++) begin
      step(1, 0, i * 4); step(1, 1, 0);
    end
    step(1, 1, 0); step(1, 1, 0);

    tag = "R3 R2 R9 spaced reads";
    for (int a = 0; a < DEPTH; a += 5) begin
      step(0, 1, a); step(1, 1, 0); step(1, 1, 0);
    end
    repeat (3) step(1, 1, 0);

    tag = "R4 read held low";
    for (int i = 0; i < 12; i++) step(0, 1, i * 3 + 2);
    repeat (3) step(1, 1, 0);

    tag = "R5 write held low";
    for (int i = 0; i < 12; i++) step(1, 0, i * 7);
    step(1, 1, 0); step(1, 1, 0);
    for (int i = 0; i < 12; i++) step(0, 1, i * 7);
    repeat (3) step(1, 1, 0);

    tag = "R6 lane masks";
    for (int i = 0; i < 8; i++) begin
      step(1, 0, i * 8 + 1, LANES'(i % 4), LANES'((i + 1) % 4));
      step(1, 1, 0, LANES'((i + 2) % 4), LANES'((i + 3) % 4));
    end
    step(1, 1, 0, LANES'(0), LANES'(3)); step(1, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 1, i * 8 + 1);
    repeat (3) step(1, 1, 0);

    tag = "R7 overlapping bursts";
    for (int i = 0; i < 24; i++) step(0, i % 3 == 0 ? 1 : 0, int'($urandom % DEPTH));
    repeat (3) step(1, 1, 0);

    tag = "R8 read-first";
    for (int i = 0; i < 6; i++) begin
      step(0, 0, i * 9 + 3); step(1, 1, 0); step(1, 1, 0); step(0, 1, i * 9 + 3); step(1, 1, 0);
    end
    repeat (3) step(1, 1, 0);

    tag = "R1 deselect and glitch";
    for (int i = 0; i < 10; i++) begin
      step(1, 1, int'($urandom % DEPTH));
      glitch(i * 6);
    end
    for (int i = 0; i < 16; i++) begin
      step(0, 1, i * 4); step(1, 1, 0);
    end
    repeat (4) step(1, 1, 0);

    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog %s run did not end", tag);
    report();
    $finish;
  end

endmodule